// File: doc/BRIEF.md
# Shared Bus Priority Arbiter

This block is the contention stage of a device that shares a parallel peripheral bus made of open-collector-style lines. A local request asks it to take the bus. It first waits until it has seen both the busy and select lines idle for a settling window. It then claims the bus by driving busy together with the one data line that stands for its own identity. After a fixed wait it reads the wired data lines back. Any identity line above its own means a stronger contender is present, so it withdraws. If none is present it drives select and holds every line steady for a guard period before it reports ownership.

All bus lines are treated as active high inside the block. Each line the block can pull has a separate drive-enable output, and the bus inputs pass through two synchronizing flops before any logic uses them. Every delay is a parameter counted in clock cycles. The result is reported as a one-cycle won or lost pulse. The owner keeps the bus until the request is withdrawn.

Top module: `bus_arbiter`

## Requirements
- R1: After reset the busy, select and data drive enables are all low, and won, lost and busy status are low.
- R2: A claim is made only after the synchronized busy and select inputs have both been low for SETTLE_CYC consecutive cycles. The inputs reach the logic through a two-flop synchronizer, so a release of busy at the pins leads to a claim SETTLE_CYC + FREE_CYC + 3 cycles later.
- R3: If the bus has been idle for a long time, busy and the single data line at index own_id are driven exactly FREE_CYC + 2 cycles after the request is sampled. A claim never comes later than SET_CYC cycles after the bus is found free.
- R4: If busy or select is seen from another device before the claim, the block drives nothing, stays busy and waits for the bus to become free again.
- R5: Exactly ARB_CYC cycles after the claim, the block loses if any data line with an index above own_id is high. Lines at or below own_id are ignored, and line 7 is the strongest.
- R6: On a loss, the lost pulse appears in the same cycle in which busy, select and the data drive are all released.
- R7: If select is seen from another device while the block is contending, all drives drop and lost pulses, at the latest CLEAR_CYC cycles after select is sampled at the pins (3 cycles with the defaults).
- R8: On a win, select is driven ARB_CYC cycles after the claim. Busy, select and the data drive then stay unchanged for CLEAR_CYC + SETTLE_CYC cycles, after which won pulses.
- R9: Won and lost last exactly one cycle. The identity is captured when the request is accepted, and the request and identity inputs are ignored while the block is busy.
- R10: The owner keeps all its drives until the request goes low. The cycle after that, every drive is released and busy status is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request to take the bus; sampled in idle, and held to keep ownership |
| own_id_i | input | 3 | Index of this device's identity line |
| bsy_i | input | 1 | Observed busy line (wired, active high) |
| sel_i | input | 1 | Observed select line (wired, active high) |
| db_i | input | 8 | Observed data lines (wired, active high) |
| bsy_oe_o | output | 1 | Drive enable for busy |
| sel_oe_o | output | 1 | Drive enable for select |
| db_oe_o | output | 8 | Drive enables for the data lines |
| won_o | output | 1 | One-cycle pulse: bus ownership gained |
| lost_o | output | 1 | One-cycle pulse: contention lost |
| busy_o | output | 1 | High whenever the block is not idle |

## Verification
The claim is due FREE_CYC + 2 edges after the request. The lost pulse or the select drive is due ARB_CYC edges after the claim, and won follows CLEAR_CYC + SETTLE_CYC edges after select. A loss caused by a foreign select is due three edges after that select is set, and a claim after the bus is released is due SETTLE_CYC + FREE_CYC + 3 edges later. The bench changes its inputs on falling edges and counts falling edges up to the event it waits for. It compares that count with these sums, so every check reads settled outputs half a period after the edge that produced them. Contenders are modelled by OR-ing the bench's own lines with the block's drive enables.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_DELAY,
        ST_ARB,
        ST_HOLD,
        ST_OWN
    } arb_state_e;

endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q, meta_d;
    logic [W-1:0] out_q, out_d;

    always_comb begin
        meta_d = d_i;
        out_d  = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            out_q  <= '0;
        end else begin
            meta_q <= meta_d;
            out_q  <= out_d;
        end
    end

    assign q_o = out_q;

endmodule

// File: rtl/arb_free_mon.sv
module arb_free_mon #(
    parameter int SETTLE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bsy_i,
    input  logic sel_i,
    output logic free_o
);
    localparam int QW = $clog2(SETTLE_CYC + 1);

    logic [QW-1:0] quiet_q, quiet_d;

    always_comb begin
        quiet_d = quiet_q;
        if (bsy_i || sel_i)
            quiet_d = '0;
        else if (quiet_q != QW'(SETTLE_CYC))
            quiet_d = quiet_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) quiet_q <= '0;
        else        quiet_q <= quiet_d;
    end

    assign free_o = (quiet_q == QW'(SETTLE_CYC));

    // R2
    free_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free_o |-> ($past(!bsy_i) && $past(!sel_i)));

endmodule

// File: rtl/arb_prio_cmp.sv
module arb_prio_cmp #(
    parameter int ID_W = 8,
    localparam int IDX_W = $clog2(ID_W)
) (
    input  logic [ID_W-1:0]  db_i,
    input  logic [IDX_W-1:0] own_idx_i,
    output logic [ID_W-1:0]  own_bit_o,
    output logic             higher_o
);
    logic [ID_W-1:0] above;

    for (genvar i = 0; i < ID_W; i++) begin : g_bit
        assign above[i]     = (IDX_W'(i) > own_idx_i);
        assign own_bit_o[i] = (IDX_W'(i) == own_idx_i);
    end

    assign higher_o = |(db_i & above);

    // R5
    always_comb begin
        own_bit_onehot_chk: assert ($onehot0(own_bit_o));
    end

endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
    import bus_arb_pkg::*;
#(
    parameter int ID_W       = 8,
    parameter int SETTLE_CYC = 4,
    parameter int FREE_CYC   = 4,
    parameter int SET_CYC    = 8,
    parameter int ARB_CYC    = 6,
    parameter int CLEAR_CYC  = 3,
    localparam int IDX_W     = $clog2(ID_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [IDX_W-1:0] own_id_i,
    input  logic             bsy_i,
    input  logic             sel_i,
    input  logic [ID_W-1:0]  db_i,
    output logic             bsy_oe_o,
    output logic             sel_oe_o,
    output logic [ID_W-1:0]  db_oe_o,
    output logic             won_o,
    output logic             lost_o,
    output logic             busy_o
);
    localparam int HOLD_CYC = CLEAR_CYC + SETTLE_CYC;
    localparam int MAX_A    = (FREE_CYC > ARB_CYC) ? FREE_CYC : ARB_CYC;
    localparam int MAX_CNT  = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
    localparam int CNT_W    = $clog2(MAX_CNT + 1);
    localparam int SYN_W    = ID_W + 2;

    typedef struct packed {
        arb_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] id;
        logic             bsy_oe;
        logic             sel_oe;
        logic             id_oe;
        logic             won;
        logic             lost;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic [SYN_W-1:0] syn_out;
    logic             bsy_s, sel_s;
    logic [ID_W-1:0]  db_s;
    logic             bus_free;
    logic             higher;
    logic [ID_W-1:0]  own_bit;

    arb_sync #(.W(SYN_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({bsy_i, sel_i, db_i}),
        .q_o   (syn_out)
    );

    assign bsy_s = syn_out[SYN_W-1];
    assign sel_s = syn_out[SYN_W-2];
    assign db_s  = syn_out[ID_W-1:0];

    arb_free_mon #(.SETTLE_CYC(SETTLE_CYC)) u_free (
        .clk    (clk),
        .rst_n  (rst_n),
        .bsy_i  (bsy_s),
        .sel_i  (sel_s),
        .free_o (bus_free)
    );

    arb_prio_cmp #(.ID_W(ID_W)) u_cmp (
        .db_i      (db_s),
        .own_idx_i (ctl_q.id),
        .own_bit_o (own_bit),
        .higher_o  (higher)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.won  = 1'b0;
        ctl_d.lost = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_i) begin
                    ctl_d.st = ST_WAIT;
                    ctl_d.id = own_id_i;
                end
            end
            ST_WAIT: begin
                if (bus_free) begin
                    ctl_d.st  = ST_DELAY;
                    ctl_d.cnt = '0;
                end
            end
            ST_DELAY: begin
                if (bsy_s || sel_s) begin
                    ctl_d.st = ST_WAIT;
                end else if (ctl_q.cnt == CNT_W'(FREE_CYC - 1)) begin
                    ctl_d.st     = ST_ARB;
                    ctl_d.cnt    = '0;
                    ctl_d.bsy_oe = 1'b1;
                    ctl_d.id_oe  = 1'b1;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            ST_ARB: begin
                if (sel_s || (ctl_q.cnt == CNT_W'(ARB_CYC - 1) && higher)) begin
                    ctl_d.st     = ST_IDLE;
                    ctl_d.bsy_oe = 1'b0;
                    ctl_d.sel_oe = 1'b0;
                    ctl_d.id_oe  = 1'b0;
                    ctl_d.lost   = 1'b1;
                end else if (ctl_q.cnt == CNT_W'(ARB_CYC - 1)) begin
                    ctl_d.st     = ST_HOLD;
                    ctl_d.cnt    = '0;
                    ctl_d.sel_oe = 1'b1;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            ST_HOLD: begin
                if (ctl_q.cnt == CNT_W'(HOLD_CYC - 1)) begin
                    ctl_d.st  = ST_OWN;
                    ctl_d.won = 1'b1;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            ST_OWN: begin
                if (!req_i) begin
                    ctl_d.st     = ST_IDLE;
                    ctl_d.bsy_oe = 1'b0;
                    ctl_d.sel_oe = 1'b0;
                    ctl_d.id_oe  = 1'b0;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, cnt: '0, id: '0, bsy_oe: 1'b0,
                       sel_oe: 1'b0, id_oe: 1'b0, won: 1'b0, lost: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign bsy_oe_o = ctl_q.bsy_oe;
    assign sel_oe_o = ctl_q.sel_oe;
    assign db_oe_o  = ctl_q.id_oe ? own_bit : '0;
    assign won_o    = ctl_q.won;
    assign lost_o   = ctl_q.lost;
    assign busy_o   = (ctl_q.st != ST_IDLE);

    localparam int WW = $clog2(SET_CYC + 2);
    localparam int AW = $clog2(CLEAR_CYC + 1);
    logic [WW-1:0] wait_age_q;
    logic [AW-1:0] sel_age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_age_q <= '0;
            sel_age_q  <= '0;
        end else begin
            if (busy_o && bus_free && !bsy_oe_o)
                wait_age_q <= (wait_age_q == WW'(SET_CYC + 1)) ? wait_age_q : wait_age_q + 1'b1;
            else
                wait_age_q <= '0;
            if (sel_s && !sel_oe_o)
                sel_age_q <= (sel_age_q == AW'(CLEAR_CYC)) ? sel_age_q : sel_age_q + 1'b1;
            else
                sel_age_q <= '0;
        end
    end

    // R2
    claim_after_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bsy_oe_o) |-> $past(bus_free));

    // R3
    claim_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wait_age_q <= WW'(SET_CYC));

    // R5
    one_id_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(db_oe_o));

    // R6
    loss_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lost_o |-> (!bsy_oe_o && !sel_oe_o && db_oe_o == '0));

    // R7
    foreign_sel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_age_q == AW'(CLEAR_CYC)) |-> (!bsy_oe_o && db_oe_o == '0));

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_oe_o && $past(sel_oe_o)) |-> (bsy_oe_o && $stable(db_oe_o)));

    // R8
    won_owns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        won_o |-> (sel_oe_o && bsy_oe_o));

    // R9
    won_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        won_o |=> !won_o);

    // R9
    lost_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lost_o |=> !lost_o);

    // R10
    release_on_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_oe_o) |-> ($past(!req_i) && !bsy_oe_o && !busy_o));

endmodule

// File: tb/bus_arbiter_bench.sv
module bus_arbiter_bench;

    localparam int FREE_CYC   = 4;
    localparam int SETTLE_CYC = 4;
    localparam int ARB_CYC    = 6;
    localparam int CLEAR_CYC  = 3;
    localparam int HOLD_CYC   = CLEAR_CYC + SETTLE_CYC;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic [2:0] own_id = 3'd0;
    logic       ext_bsy = 1'b0, ext_sel = 1'b0;
    logic [7:0] ext_db = 8'h00;
    logic       bsy_oe, sel_oe, won, lost, busy;
    logic [7:0] db_oe;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    bus_arbiter u_bus_arbiter (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req),
        .own_id_i (own_id),
        .bsy_i    (bsy_oe | ext_bsy),
        .sel_i    (sel_oe | ext_sel),
        .db_i     (db_oe | ext_db),
        .bsy_oe_o (bsy_oe),
        .sel_oe_o (sel_oe),
        .db_oe_o  (db_oe),
        .won_o    (won),
        .lost_o   (lost),
        .busy_o   (busy)
    );

    // {own_id[2:0], contenders[7:0], expect_win}
    localparam logic [11:0] VEC [8] = '{
        {3'd3, 8'h00, 1'b1},
        {3'd3, 8'h04, 1'b1},
        {3'd3, 8'h10, 1'b0},
        {3'd7, 8'h7F, 1'b1},
        {3'd0, 8'h80, 1'b0},
        {3'd5, 8'h40, 1'b0},
        {3'd2, 8'h03, 1'b1},
        {3'd6, 8'h80, 1'b0}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_claim(output int n);
        n = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            n++;
            if (bsy_oe) break;
        end
    endtask

    task automatic wait_won(output int n);
        n = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            n++;
            if (won) break;
        end
    endtask

    task automatic run_vec(input logic [2:0] id, input logic [7:0] cont, input bit win);
        int n;
        int m;
        logic [7:0] held;
        own_id = id;
        req = 1'b1;
        wait_claim(n);
        // R3: claim timing and own line
        chk(n == FREE_CYC + 2, "R3 claim cycles", n, FREE_CYC + 2);
        chk(db_oe == (8'h01 << id), "R3 own id line", db_oe, 8'h01 << id);
        ext_db = cont;
        ext_bsy = (cont != 8'h00);
        m = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            m++;
            if (lost || sel_oe) break;
        end
        if (win) begin
            // R5 / R8: select after ARB_CYC
            chk(sel_oe && !lost && m == ARB_CYC, "R5 R8 win select time", m, ARB_CYC);
            ext_db = 8'h00;
            ext_bsy = 1'b0;
            held = db_oe;
            wait_won(m);
            // R8: guard period
            chk(m == HOLD_CYC, "R8 won after guard", m, HOLD_CYC);
            chk(bsy_oe && sel_oe && db_oe == held, "R8 drives held", db_oe, held);
            @(negedge clk);
            // R9
            chk(!won, "R9 won one cycle", won, 0);
            req = 1'b0;
            @(negedge clk);
            // R10
            chk(!bsy_oe && !sel_oe && db_oe == 0 && !busy, "R10 release",
                {bsy_oe, sel_oe, busy}, 0);
        end else begin
            // R5 / R6
            chk(lost && m == ARB_CYC, "R5 loss time", m, ARB_CYC);
            chk(!bsy_oe && !sel_oe && db_oe == 0, "R6 drives off on loss",
                {bsy_oe, sel_oe, db_oe}, 0);
            req = 1'b0;
            ext_db = 8'h00;
            ext_bsy = 1'b0;
            @(negedge clk);
            // R9
            chk(!lost && !busy, "R9 lost one cycle", lost, 0);
        end
        idle(20);
    endtask

    initial begin
        #(20 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        logic [11:0] v;
        idle(3);
        // R1: reset state
        chk(!bsy_oe && !sel_oe && db_oe == 0 && !won && !lost && !busy,
            "R1 reset state", {bsy_oe, sel_oe, db_oe, won, lost, busy}, 0);
        rst_n = 1'b1;
        idle(12);

        for (int k = 0; k < 8; k++) begin
            v = VEC[k];
            run_vec(v[11:9], v[8:1], v[0]);
        end

        // R4 / R2: foreign busy before the claim, then release
        own_id = 3'd4;
        req = 1'b1;
        @(negedge clk);
        ext_bsy = 1'b1;
        n = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (bsy_oe || db_oe != 0) n++;
        end
        chk(n == 0, "R4 no drive while bus taken", n, 0);
        chk(busy, "R4 still waiting", busy, 1);
        ext_bsy = 1'b0;
        wait_claim(n);
        chk(n == SETTLE_CYC + FREE_CYC + 3, "R2 claim after release", n,
            SETTLE_CYC + FREE_CYC + 3);
        wait_won(n);
        req = 1'b0;
        idle(20);

        // R7: foreign select during contention
        own_id = 3'd7;
        req = 1'b1;
        wait_claim(n);
        ext_sel = 1'b1;
        n = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            n++;
            if (lost) break;
        end
        chk(lost && n == 3, "R7 loss on foreign select", n, 3);
        chk(!bsy_oe && db_oe == 0 && !sel_oe, "R7 drives dropped", db_oe, 0);
        ext_sel = 1'b0;
        req = 1'b0;
        idle(20);

        // R9: identity captured at acceptance, changes ignored while busy
        own_id = 3'd1;
        req = 1'b1;
        wait_claim(n);
        own_id = 3'd6;
        idle(2);
        chk(db_oe == 8'h02, "R9 identity ignored while busy", db_oe, 8'h02);
        wait_won(n);
        chk(won && db_oe == 8'h02, "R9 won with captured identity", db_oe, 8'h02);
        idle(3);
        chk(bsy_oe && sel_oe && busy, "R10 hold while requested", {bsy_oe, sel_oe, busy}, 7);
        req = 1'b0;
        @(negedge clk);
        chk(!bsy_oe && !sel_oe && !busy, "R10 release after drop", {bsy_oe, sel_oe, busy}, 0);
        idle(5);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule